// File: doc/BRIEF.md
# Cascaded Audio Converter Clock Generator

This block derives the three clocks an audio ADC/DAC pair needs from one system reference clock. The master clock comes from the reference through a programmable divider. The bit clock counts master-clock edges, and the frame clock counts bit-clock edges. The last two stages use fixed ratios that are set as parameters. All three stages run on the reference clock, and each stage advances only when the stage before it wraps.

Software, or a neighbouring block, presents a requested sample rate and pulses `load`. The block clamps the rate to a legal window. A sequential divider then turns the rate into a master-clock divisor and computes the sample rate that the chain will really produce. When both results are ready, the block asserts the active-low driver enable.

A `start` pulse enables the master, bit and frame clocks in that order, one reference cycle apart. The first frame-clock period is stretched so that the frame clock settles into a fixed phase against the bit clock. A `stop` pulse clears and disables all three stages.

Top module: `convclk_gen`

## Requirements
- R1: A requested rate below RATE_MIN is treated as RATE_MIN, and one above RATE_MAX is treated as RATE_MAX, before any division takes place.
- R2: When `busy` falls after a load, `mclk_div` equals floor(REF_FREQ / (clamped_rate × MS_RATIO × SL_RATIO)).
- R3: While running, `mclk_o` rises every `mclk_div` reference cycles. After its first period, `sclk_o` rises every MS_RATIO master periods. After its first period, `lrclk_o` rises every SL_RATIO bit-clock rises.
- R4: In the cycle after `stop` is sampled high, all three clock outputs are low, and they stay low until a later accepted start. `stop` wins over a simultaneous `start`.
- R5: In the first cycle after an accepted start, `mclk_o` is high while `sclk_o` and `lrclk_o` are low. `sclk_o` goes high one cycle later, and `lrclk_o` goes high one cycle after that.
- R6: The first frame-clock period after a start spans LR_DELAY + SL_RATIO/2 − 1 bit-clock rises. Every later period spans SL_RATIO.
- R7: When `busy` falls after a load, `rate_actual` equals floor(REF_FREQ / (mclk_div × MS_RATIO × SL_RATIO)).
- R8: `drv_en_n` is high from reset until the first load completes. It then stays low until the next reset.
- R9: `busy` is high while the divisors are being computed, and all clock outputs stay low during that time. A `start` pulse while `busy` is high is ignored.
- R10: A `load` while the clocks run is ignored, so `mclk_div` and `rate_actual` keep their values. A `start` before any completed load is ignored.
- R11: After reset, `busy`, `mclk_div`, `rate_actual` and all clock outputs are zero, and `drv_en_n` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_req | input | RATE_W | Requested sample rate in Hz |
| load | input | 1 | Pulse: clamp `rate_req` and compute divisors |
| start | input | 1 | Pulse: begin ordered clock start-up |
| stop | input | 1 | Pulse: clear and disable all stages |
| busy | output | 1 | Divisor computation in progress |
| mclk_div | output | DIV_W | Master-clock divisor in reference cycles |
| rate_actual | output | RATE_W | Sample rate the chain produces |
| drv_en_n | output | 1 | Active-low clock-driver enable |
| mclk_o | output | 1 | Master clock |
| sclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |

## Verification
The checker watches several properties on every cycle: the edge counts between bit-clock and frame-clock rises, the stretched first frame period, the stop-to-quiet timing, the enable order, silence while busy, and the sticky driver enable. Only the bench can show the arithmetic results. It sweeps every requested rate across and beyond the clamp window and compares `mclk_div` and `rate_actual` against values computed directly. The bench scenarios also cover the exact start-up cycle pattern, the master-clock period in reference cycles, and the ignored `start` and `load` cases.

// File: rtl/convclk_pkg.sv
package convclk_pkg;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_DIV_M = 2'd1,
      CS_DIV_R = 2'd2
   } calc_state_t;

   // Length of the stretched first frame period, in bit-clock rises.
   function automatic int unsigned first_frame_len(int unsigned delay, int unsigned sl_ratio);
      return delay + sl_ratio / 2 - 1;
   endfunction

   function automatic int unsigned max_u(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/convclk_rdiv.sv
// Restoring divider: one quotient bit per cycle, W cycles per result.
module convclk_rdiv #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quot
);
   localparam int SW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("convclk_rdiv: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  rem;
   logic [W-1:0]  q;
   logic [W-1:0]  den_r;
   logic [SW-1:0] steps;
   logic [W:0]    shifted;
   logic [W:0]    trial;

   assign shifted = {rem, q[W-1]};
   assign trial   = shifted - {1'b0, den_r};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         q     <= '0;
         den_r <= '0;
         steps <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else if (go && !busy) begin
         rem   <= '0;
         q     <= num;
         den_r <= den;
         steps <= SW'(W);
         busy  <= 1'b1;
         done  <= 1'b0;
      end else if (busy) begin
         if (!trial[W]) begin
            rem <= trial[W-1:0];
            q   <= {q[W-2:0], 1'b1};
         end else begin
            rem <= shifted[W-1:0];
            q   <= {q[W-2:0], 1'b0};
         end
         steps <= steps - SW'(1);
         if (steps == SW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assign quot = q;

endmodule

// File: rtl/convclk_stage.sv
// One divider stage of the cascade. It counts input ticks and wraps after
// n_eff ticks, optionally using a longer count for its first period.
module convclk_stage #(
   parameter int CW        = 8,
   parameter bit HAS_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          en,
   input  logic          tick_in,
   input  logic [CW-1:0] n_main,
   input  logic [CW-1:0] n_first,
   output logic          tick_out,
   output logic          clk_out
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] n_eff;
   logic [CW:0]   high_len;

   generate
      if (HAS_FIRST) begin : g_first
         logic first_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        first_q <= 1'b1;
            else if (srst)     first_q <= 1'b1;
            else if (tick_out) first_q <= 1'b0;
         end
         assign n_eff = first_q ? n_first : n_main;
      end else begin : g_plain
         logic unused_first;
         assign unused_first = ^n_first;
         assign n_eff = n_main;
      end
   endgenerate

   assign tick_out = en & tick_in & (cnt == n_eff - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (srst)          cnt <= '0;
      else if (en && tick_in) cnt <= tick_out ? '0 : cnt + CW'(1);
   end

   // High for the first ceil(n_eff/2) counts of each period.
   assign high_len = ({1'b0, n_eff} + (CW + 1)'(1)) >> 1;
   assign clk_out  = en & ({1'b0, cnt} < high_len);

endmodule

// File: rtl/convclk_gen.sv
module convclk_gen
   import convclk_pkg::*;
#(
   parameter int unsigned REF_FREQ = 49_152_000,
   parameter int unsigned RATE_MIN = 8000,
   parameter int unsigned RATE_MAX = 48000,
   parameter int unsigned MS_RATIO = 4,
   parameter int unsigned SL_RATIO = 64,
   parameter int unsigned LR_DELAY = 38,
   parameter int          RATE_W   = 20,
   localparam int unsigned PROD      = MS_RATIO * SL_RATIO,
   localparam int unsigned FIRST_CNT = first_frame_len(LR_DELAY, SL_RATIO),
   localparam int unsigned DIV_MAX   = REF_FREQ / (RATE_MIN * PROD),
   localparam int          DIV_W     = $clog2(DIV_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_req,
   input  logic              load,
   input  logic              start,
   input  logic              stop,
   output logic              busy,
   output logic [DIV_W-1:0]  mclk_div,
   output logic [RATE_W-1:0] rate_actual,
   output logic              drv_en_n,
   output logic              mclk_o,
   output logic              sclk_o,
   output logic              lrclk_o
);
   localparam int NUM_W = $clog2(REF_FREQ + 1);
   localparam int SC_W  = $clog2(MS_RATIO + 1);
   localparam int LR_W  = $clog2(max_u(FIRST_CNT, SL_RATIO) + 1);
   localparam logic [NUM_W-1:0] REF_N  = NUM_W'(REF_FREQ);
   localparam logic [NUM_W-1:0] PROD_N = NUM_W'(PROD);

   // Elaboration-time parameter checks
   generate
      if (MS_RATIO < 2) begin : g_bad_ms
         $error("convclk_gen: MS_RATIO must be at least 2");
      end
      if (SL_RATIO < 2) begin : g_bad_sl
         $error("convclk_gen: SL_RATIO must be at least 2");
      end
      if (RATE_MIN < 1 || RATE_MIN > RATE_MAX) begin : g_bad_window
         $error("convclk_gen: rate window is empty");
      end
      if (REF_FREQ < 2 * RATE_MAX * PROD) begin : g_bad_ref
         $error("convclk_gen: reference too slow for a master divisor of two");
      end
      if (RATE_MAX >= (64'd1 << RATE_W)) begin : g_bad_rw
         $error("convclk_gen: RATE_W too narrow for RATE_MAX");
      end
      if (FIRST_CNT < 2) begin : g_bad_first
         $error("convclk_gen: stretched first frame count below two");
      end
   endgenerate

   // ---------------- rate clamp ----------------
   logic [RATE_W-1:0] rate_clamped;
   always_comb begin
      if (rate_req < RATE_W'(RATE_MIN))      rate_clamped = RATE_W'(RATE_MIN);
      else if (rate_req > RATE_W'(RATE_MAX)) rate_clamped = RATE_W'(RATE_MAX);
      else                                   rate_clamped = rate_req;
   end

   // ---------------- control state ----------------
   calc_state_t       cstate;
   logic [DIV_W-1:0]  mdiv_r;
   logic [RATE_W-1:0] rate_r;
   logic              loaded;
   logic              drv_n;
   logic              en_m, en_s, en_l;
   logic              srst;
   logic              load_ok, start_ok;

   assign load_ok  = load && (cstate == CS_IDLE) && !en_m;
   assign start_ok = start && !stop && loaded && (cstate == CS_IDLE);

   // ---------------- shared divider ----------------
   logic              dv_go, dv_done, dv_busy_unused;
   logic [NUM_W-1:0]  dv_den, dv_quot;

   always_comb begin
      dv_go  = 1'b0;
      dv_den = '0;
      case (cstate)
         CS_IDLE: begin
            if (load_ok) begin
               dv_go  = 1'b1;
               dv_den = NUM_W'(rate_clamped) * PROD_N;
            end
         end
         CS_DIV_M: begin
            if (dv_done) begin
               dv_go  = 1'b1;
               dv_den = dv_quot * PROD_N;
            end
         end
         default: ;
      endcase
   end

   convclk_rdiv #(.W(NUM_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (dv_go),
      .num  (REF_N),
      .den  (dv_den),
      .busy (dv_busy_unused),
      .done (dv_done),
      .quot (dv_quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cstate <= CS_IDLE;
         mdiv_r <= '0;
         rate_r <= '0;
         loaded <= 1'b0;
         drv_n  <= 1'b1;
      end else begin
         case (cstate)
            CS_IDLE: begin
               if (load_ok) cstate <= CS_DIV_M;
            end
            CS_DIV_M: begin
               if (dv_done) begin
                  mdiv_r <= DIV_W'(dv_quot);
                  cstate <= CS_DIV_R;
               end
            end
            CS_DIV_R: begin
               if (dv_done) begin
                  rate_r <= RATE_W'(dv_quot);
                  loaded <= 1'b1;
                  drv_n  <= 1'b0;
                  cstate <= CS_IDLE;
               end
            end
            default: cstate <= CS_IDLE;
         endcase
      end
   end

   // ---------------- start / stop sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_m <= 1'b0;
         en_s <= 1'b0;
         en_l <= 1'b0;
         srst <= 1'b0;
      end else if (stop) begin
         en_m <= 1'b0;
         en_s <= 1'b0;
         en_l <= 1'b0;
         srst <= 1'b1;
      end else begin
         srst <= 1'b0;
         if (start_ok) en_m <= 1'b1;
         en_s <= en_m;
         en_l <= en_s;
      end
   end

   // ---------------- cascaded stages ----------------
   logic m_tick, s_tick, lr_wrap_unused;

   convclk_stage #(.CW(DIV_W), .HAS_FIRST(1'b0)) u_mstage (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .en      (en_m),
      .tick_in (1'b1),
      .n_main  (mdiv_r),
      .n_first (mdiv_r),
      .tick_out(m_tick),
      .clk_out (mclk_o)
   );

   convclk_stage #(.CW(SC_W), .HAS_FIRST(1'b0)) u_sstage (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .en      (en_s),
      .tick_in (m_tick),
      .n_main  (SC_W'(MS_RATIO)),
      .n_first (SC_W'(MS_RATIO)),
      .tick_out(s_tick),
      .clk_out (sclk_o)
   );

   convclk_stage #(.CW(LR_W), .HAS_FIRST(1'b1)) u_lstage (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .en      (en_l),
      .tick_in (s_tick),
      .n_main  (LR_W'(SL_RATIO)),
      .n_first (LR_W'(FIRST_CNT)),
      .tick_out(lr_wrap_unused),
      .clk_out (lrclk_o)
   );

   assign busy        = (cstate != CS_IDLE);
   assign mclk_div    = mdiv_r;
   assign rate_actual = rate_r;
   assign drv_en_n    = drv_n;

endmodule

// File: rtl/convclk_chk.sv
module convclk_chk #(
   parameter int unsigned MS_RATIO  = 4,
   parameter int unsigned SL_RATIO  = 64,
   parameter int unsigned FIRST_CNT = 69
) (
   input logic clk,
   input logic rst_n,
   input logic stop,
   input logic busy,
   input logic drv_en_n,
   input logic mclk_o,
   input logic sclk_o,
   input logic lrclk_o,
   input logic en_m,
   input logic en_s,
   input logic en_l
);
   logic        m_q, s_q, l_q;
   logic        m_rise, s_rise, l_rise;
   int unsigned mcnt, scnt;
   logic        s_armed;
   logic [1:0]  lr_st;

   assign m_rise = mclk_o & ~m_q;
   assign s_rise = sclk_o & ~s_q;
   assign l_rise = lrclk_o & ~l_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= 1'b0; s_q <= 1'b0; l_q <= 1'b0;
         mcnt <= 0; scnt <= 0; s_armed <= 1'b0; lr_st <= 2'd0;
      end else begin
         m_q <= mclk_o; s_q <= sclk_o; l_q <= lrclk_o;
         if (s_rise) mcnt <= 0;
         else        mcnt <= mcnt + 32'(m_rise);
         if (l_rise) scnt <= 0;
         else        scnt <= scnt + 32'(s_rise);
         if (stop) begin
            s_armed <= 1'b0;
            lr_st   <= 2'd0;
         end else begin
            if (s_rise) s_armed <= 1'b1;
            if (l_rise && lr_st != 2'd2) lr_st <= lr_st + 2'd1;
         end
      end
   end

   a_r3_sclk_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rise && s_armed) |-> (mcnt + 32'(m_rise) == MS_RATIO));

   a_r3_lrclk_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rise && lr_st == 2'd2) |-> (scnt + 32'(s_rise) == SL_RATIO));

   a_r6_first_period: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rise && lr_st == 2'd1) |-> (scnt + 32'(s_rise) == FIRST_CNT));

   a_r4_stop_quiets: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!mclk_o && !sclk_o && !lrclk_o));

   a_r5_sclk_after_mclk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_s) |-> en_m);

   a_r5_lrclk_after_sclk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_l) |-> (en_s && en_m));

   a_r8_drv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en_n |=> !drv_en_n);

   a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!mclk_o && !sclk_o && !lrclk_o));

endmodule

bind convclk_gen convclk_chk #(
   .MS_RATIO (MS_RATIO),
   .SL_RATIO (SL_RATIO),
   .FIRST_CNT(FIRST_CNT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .stop    (stop),
   .busy    (busy),
   .drv_en_n(drv_en_n),
   .mclk_o  (mclk_o),
   .sclk_o  (sclk_o),
   .lrclk_o (lrclk_o),
   .en_m    (en_m),
   .en_s    (en_s),
   .en_l    (en_l)
);

// File: tb/sim_convclk_gen.sv
module sim_convclk_gen;
   localparam int CLK_PERIOD = 10;
   localparam int REF   = 9600;
   localparam int RMIN  = 100;
   localparam int RMAX  = 600;
   localparam int MS    = 2;
   localparam int SL    = 4;
   localparam int LRD   = 5;
   localparam int RW    = 12;
   localparam int FIRST = LRD + SL / 2 - 1;
   localparam int DW    = $clog2(REF / (RMIN * MS * SL) + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] rate_req = '0;
   logic          load = 1'b0, start = 1'b0, stop = 1'b0;
   logic          busy, drv_en_n, mclk_o, sclk_o, lrclk_o;
   logic [DW-1:0] mclk_div;
   logic [RW-1:0] rate_actual;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   convclk_gen #(
      .REF_FREQ(REF), .RATE_MIN(RMIN), .RATE_MAX(RMAX),
      .MS_RATIO(MS), .SL_RATIO(SL), .LR_DELAY(LRD), .RATE_W(RW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .load(load),
      .start(start), .stop(stop), .busy(busy), .mclk_div(mclk_div),
      .rate_actual(rate_actual), .drv_en_n(drv_en_n),
      .mclk_o(mclk_o), .sclk_o(sclk_o), .lrclk_o(lrclk_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic int clampr(input int r);
      if (r < RMIN) return RMIN;
      if (r > RMAX) return RMAX;
      return r;
   endfunction

   function automatic int ediv(input int r);
      return REF / (clampr(r) * MS * SL);
   endfunction

   function automatic int erate(input int d);
      return REF / (d * MS * SL);
   endfunction

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   task automatic do_load(input int r);
      @(negedge clk);
      rate_req = RW'(r);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      wait_idle();
   endtask

   task automatic clocks_low(input string req, input string what);
      chk(req, what, {29'd0, mclk_o, sclk_o, lrclk_o}, 0);
   endtask

   // Start the chain at rate r and measure periods over four frame rises.
   task automatic run_test(input int r);
      int d, pm, ps, pl, last_m, last_s, n_sr, s_since, l_rises;
      do_load(r);
      d = ediv(r);
      chk("R2", "divisor before run", int'(mclk_div), d);
      pm = 0; ps = 0; pl = 0; last_m = -1; last_s = -1;
      n_sr = 0; s_since = 0; l_rises = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 2000 && l_rises < 4; cyc++) begin
         int m, s, l, mr, sr, lr;
         if (cyc > 0) @(negedge clk);
         m = int'(mclk_o); s = int'(sclk_o); l = int'(lrclk_o);
         if (cyc == 0) chk("R5", "cycle0 m/s/l", m * 4 + s * 2 + l, 4);
         if (cyc == 1) chk("R5", "cycle1 s/l", s * 2 + l, 2);
         if (cyc == 2) chk("R5", "cycle2 l", l, 1);
         mr = m & ~pm; sr = s & ~ps; lr = l & ~pl;
         if (mr != 0) begin
            if (last_m >= 0) chk("R3", "mclk period", cyc - last_m, d);
            last_m = cyc;
         end
         if (sr != 0) begin
            n_sr++;
            if (n_sr >= 3) chk("R3", "sclk period", cyc - last_s, d * MS);
            last_s = cyc;
         end
         if (lr != 0) begin
            if (l_rises == 1) chk("R6", "first frame sclk count", s_since + sr, FIRST);
            if (l_rises >= 2) chk("R3", "frame sclk count", s_since + sr, SL);
            s_since = 0;
            l_rises++;
         end else begin
            s_since += sr;
         end
         pm = m; ps = s; pl = l;
      end
      chk("R3", "frame rises seen", l_rises, 4);
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      clocks_low("R4", "clocks after stop");
      repeat (10) @(negedge clk);
      clocks_low("R4", "clocks stay low");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog actual=expired expected=completion");
      summary();
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "busy", int'(busy), 0);
      chk("R11", "mclk_div", int'(mclk_div), 0);
      chk("R11", "rate_actual", int'(rate_actual), 0);
      chk("R11", "drv_en_n", int'(drv_en_n), 1);
      clocks_low("R11", "clocks");

      // R10: start without a loaded divisor is ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      clocks_low("R10", "start before load");
      chk("R8", "drv before load", int'(drv_en_n), 1);

      // R1, R2, R7: sweep across and beyond the clamp window
      for (int r = 0; r <= 700; r++) begin
         do_load(r);
         chk("R2", $sformatf("mclk_div rate=%0d", r), int'(mclk_div), ediv(r));
         chk("R7", $sformatf("rate_actual rate=%0d", r), int'(rate_actual), erate(ediv(r)));
      end
      do_load(4095);
      chk("R1", "max code clamps high", int'(mclk_div), REF / (RMAX * MS * SL));
      do_load(1);
      chk("R1", "tiny rate clamps low", int'(mclk_div), REF / (RMIN * MS * SL));
      chk("R8", "drv after load", int'(drv_en_n), 0);

      // R9: start during computation is ignored
      @(negedge clk);
      rate_req = RW'(300);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk("R9", "busy after load", int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (4) @(negedge clk);
      clocks_low("R9", "start while busy");
      chk("R2", "divisor at 300", int'(mclk_div), ediv(300));

      // R3, R4, R5, R6 at several divisors
      run_test(100);
      run_test(400);
      run_test(600);
      run_test(250);
      chk("R8", "drv after stop", int'(drv_en_n), 0);

      // R10: load while running is ignored
      do_load(200);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      rate_req = RW'(600);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", "busy on running load", int'(busy), 0);
      chk("R10", "mclk_div kept", int'(mclk_div), ediv(200));
      chk("R10", "rate_actual kept", int'(rate_actual), erate(ediv(200)));
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;

      // R4: stop beats a simultaneous start
      @(negedge clk);
      start = 1'b1;
      stop = 1'b1;
      @(negedge clk);
      start = 1'b0;
      stop = 1'b0;
      clocks_low("R4", "stop with start");
      repeat (5) @(negedge clk);
      clocks_low("R4", "stop with start later");

      summary();
      $finish;
   end

endmodule